// File: doc/BRIEF.md
# Domain Access Checker with Fault Capture

This block sits beside the translation logic of a memory management unit and applies a per-domain access policy to every translated access. A 32-bit control register holds a 2-bit policy code for each of sixteen domains. For each access the block takes the access's 4-bit domain number and a pass/fail result from the descriptor permission logic. It then either lets the access through or raises a fault. Some policy codes consult the permission result and others ignore it.

The four policy codes are as follows. Code 00 blocks the domain outright. Code 10 is reserved and behaves exactly like 00. Code 01 makes the access depend on the permission result. Code 11 grants every access without looking at permissions. When the MMU is switched off, every valid access is granted.

The first fault of an access raises a one-cycle pulse that carries a 4-bit fault code. On the same clock edge the block records a fault status word and the faulting address. These two records keep their values until a later access faults.

Top module: `domain_guard`

## Requirements
- R1: After reset the policy register, the status word, the fault address and the fault pulse all read zero. A write to the policy register appears on `dacr_q` from the cycle after the write.
- R2: Bits 2d+1:2d of the policy register hold the policy code for domain d. An access uses only its own domain's field.
- R3: Under policy 00 with the MMU on, a valid access is not granted and causes a domain fault, status code 4'h9.
- R4: Policy 10 behaves exactly like policy 00: no grant, and a domain fault with status code 4'h9.
- R5: Under policy 01 with the MMU on, a valid access is granted when `perm_ok` is 1. When `perm_ok` is 0 the access is refused and causes a permission fault, status code 4'hD.
- R6: Under policy 11 a valid access is always granted, and no fault is raised whatever the value of `perm_ok`.
- R7: While `mmu_on` is 0, every valid access is granted and no fault of either kind is raised.
- R8: `fault_pulse` and `fault_code` appear in the cycle after the first faulting cycle of an access and last exactly one cycle. An access that keeps `acc_valid` high over several faulting cycles produces only one pulse.
- R9: The status word holds the fault code in bits 3:0, the domain number in bits 7:4, zero in bits 11:8, and zero in every bit above 11.
- R10: `far_q` and `fsr_q` change only on a first fault, and then take the access address and status word of that fault. Accesses that do not fault leave both unchanged.
- R11: While `acc_valid` is 0, `acc_grant` is 0 and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dacr_wr | input | 1 | Load strobe for the policy register |
| dacr_wdata | input | 32 | New policy register value |
| dacr_q | output | 32 | Current policy register value |
| mmu_on | input | 1 | MMU enable; when low, all checks are bypassed |
| acc_valid | input | 1 | An access is presented; held high for the length of the access |
| acc_domain | input | 4 | Domain number of the access |
| acc_addr | input | 32 | Address of the access |
| perm_ok | input | 1 | Result from the descriptor permission logic (1 = allowed) |
| acc_grant | output | 1 | The access may proceed (combinational) |
| fault_pulse | output | 1 | One-cycle pulse on the first fault of an access |
| fault_code | output | 4 | Fault code while `fault_pulse` is high, zero otherwise |
| fsr_q | output | 32 | Captured fault status word |
| far_q | output | 32 | Captured fault address |

## Verification
`acc_grant` is a combinational function of the current inputs and the policy register. The bench reads it a short delay after driving an access, inside the same cycle. The fault pulse, fault code, status word and fault address are registered and are due one clock edge after the faulting cycle. The bench therefore reads them at the falling edge that follows that rising edge. One cycle later it confirms that the pulse has dropped. Policy register writes are read back one cycle after the write strobe. The bench sweeps every domain under every policy code, with both values of `perm_ok` and both MMU states. In each case the other fifteen domains carry the complementary code, so a field picked from the wrong position produces a visible error.

// File: rtl/dg_pkg.sv
package dg_pkg;

   typedef enum logic [1:0] {
      POL_BLOCK  = 2'b00,
      POL_CLIENT = 2'b01,
      POL_RSVD   = 2'b10,
      POL_MGR    = 2'b11
   } dom_pol_e;

   localparam logic [3:0] FLT_DOMAIN = 4'h9;
   localparam logic [3:0] FLT_PERM   = 4'hD;

   // Width of one policy field in the control register.
   localparam int unsigned POL_W = 2;

endpackage

// File: rtl/dg_ctrl_reg.sv
module dg_ctrl_reg #(
   parameter int unsigned CTRL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= wdata;
   end

endmodule

// File: rtl/dg_policy.sv
module dg_policy
   import dg_pkg::*;
#(
   parameter int unsigned DOM_W = 4,
   localparam int unsigned NUM_DOM = 1 << DOM_W,
   localparam int unsigned CTRL_W  = POL_W * NUM_DOM
) (
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [DOM_W-1:0]  domain,
   input  logic              valid,
   input  logic              mmu_on,
   input  logic              perm_ok,
   output logic              grant,
   output logic              dom_flt,
   output logic              perm_flt
);

   dom_pol_e pol_arr [NUM_DOM];
   dom_pol_e pol;

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_field
      assign pol_arr[d] = dom_pol_e'(ctrl[POL_W*d +: POL_W]);
   end

   assign pol = pol_arr[domain];

   always_comb begin
      grant    = 1'b0;
      dom_flt  = 1'b0;
      perm_flt = 1'b0;
      if (valid) begin
         if (!mmu_on) begin
            grant = 1'b1;
         end else begin
            unique case (pol)
               POL_BLOCK, POL_RSVD: dom_flt = 1'b1;
               POL_CLIENT: begin
                  grant    = perm_ok;
                  perm_flt = !perm_ok;
               end
               POL_MGR: grant = 1'b1;
               default: dom_flt = 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/dg_fault_capture.sv
module dg_fault_capture
   import dg_pkg::*;
#(
   parameter int unsigned DOM_W  = 4,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned FSR_W  = 32,
   parameter int unsigned ZERO_W = 4,
   localparam int unsigned DEF_W = 8 + ZERO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              dom_flt,
   input  logic              perm_flt,
   input  logic [DOM_W-1:0]  domain,
   input  logic [ADDR_W-1:0] addr,
   output logic              fault_pulse,
   output logic [3:0]        fault_code,
   output logic [FSR_W-1:0]  fsr_q,
   output logic [ADDR_W-1:0] far_q
);

   logic             faulted_q;
   logic             first_flt;
   logic [3:0]       code_now;
   logic [DEF_W-1:0] def_word;
   logic [FSR_W-1:0] word;

   assign first_flt = valid && (dom_flt || perm_flt) && !faulted_q;
   assign code_now  = dom_flt ? FLT_DOMAIN : FLT_PERM;

   always_comb begin
      def_word              = '0;
      def_word[3:0]         = code_now;
      def_word[4 +: DOM_W]  = domain;
   end

   if (FSR_W > DEF_W) begin : g_pad
      assign word = {{(FSR_W-DEF_W){1'b0}}, def_word};
   end else begin : g_nopad
      assign word = def_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         faulted_q   <= 1'b0;
         fault_pulse <= 1'b0;
         fault_code  <= '0;
         fsr_q       <= '0;
         far_q       <= '0;
      end else begin
         faulted_q   <= valid && (faulted_q || first_flt);
         fault_pulse <= first_flt;
         fault_code  <= first_flt ? code_now : 4'h0;
         if (first_flt) begin
            fsr_q <= word;
            far_q <= addr;
         end
      end
   end

endmodule

// File: rtl/domain_guard.sv
module domain_guard
   import dg_pkg::*;
#(
   parameter int unsigned DOM_W  = 4,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned FSR_W  = 32,
   parameter int unsigned ZERO_W = 4,
   localparam int unsigned NUM_DOM = 1 << DOM_W,
   localparam int unsigned CTRL_W  = POL_W * NUM_DOM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dacr_wr,
   input  logic [CTRL_W-1:0] dacr_wdata,
   output logic [CTRL_W-1:0] dacr_q,
   input  logic              mmu_on,
   input  logic              acc_valid,
   input  logic [DOM_W-1:0]  acc_domain,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              perm_ok,
   output logic              acc_grant,
   output logic              fault_pulse,
   output logic [3:0]        fault_code,
   output logic [FSR_W-1:0]  fsr_q,
   output logic [ADDR_W-1:0] far_q
);

   if (DOM_W < 1 || DOM_W > 4) begin : g_bad_dom
      $error("DOM_W must lie in 1..4 to fit the status domain field");
   end
   if (ZERO_W != 1 && ZERO_W != 4) begin : g_bad_zero
      $error("ZERO_W must be 1 or 4");
   end
   if (FSR_W < 8 + ZERO_W) begin : g_bad_fsr
      $error("FSR_W too small for the defined status fields");
   end

   logic dom_flt, perm_flt;

   dg_ctrl_reg #(.CTRL_W(CTRL_W)) i_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (dacr_wr),
      .wdata (dacr_wdata),
      .q     (dacr_q)
   );

   dg_policy #(.DOM_W(DOM_W)) i_policy (
      .ctrl     (dacr_q),
      .domain   (acc_domain),
      .valid    (acc_valid),
      .mmu_on   (mmu_on),
      .perm_ok  (perm_ok),
      .grant    (acc_grant),
      .dom_flt  (dom_flt),
      .perm_flt (perm_flt)
   );

   dg_fault_capture #(
      .DOM_W  (DOM_W),
      .ADDR_W (ADDR_W),
      .FSR_W  (FSR_W),
      .ZERO_W (ZERO_W)
   ) i_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid       (acc_valid),
      .dom_flt     (dom_flt),
      .perm_flt    (perm_flt),
      .domain      (acc_domain),
      .addr        (acc_addr),
      .fault_pulse (fault_pulse),
      .fault_code  (fault_code),
      .fsr_q       (fsr_q),
      .far_q       (far_q)
   );

endmodule

// File: rtl/domain_guard_chk.sv
module domain_guard_chk #(
   parameter int unsigned DOM_W  = 4,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned FSR_W  = 32,
   localparam int unsigned CTRL_W = 2 << DOM_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CTRL_W-1:0] dacr_q,
   input logic              mmu_on,
   input logic              acc_valid,
   input logic [DOM_W-1:0]  acc_domain,
   input logic              acc_grant,
   input logic              fault_pulse,
   input logic [3:0]        fault_code,
   input logic [FSR_W-1:0]  fsr_q,
   input logic [ADDR_W-1:0] far_q
);

   logic [1:0] fld;
   assign fld = dacr_q[{acc_domain, 1'b0} +: 2];

   AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !acc_grant);                                   // R11
   AST_BLOCKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && mmu_on && !fld[0]) |-> !acc_grant);             // R4
   AST_MANAGER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && mmu_on && fld == 2'b11) |-> acc_grant);         // R6
   AST_MMU_OFF_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !mmu_on) |=> !fault_pulse);                     // R7
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |=> !fault_pulse);                                // R8
   AST_CODE_ONLY_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_pulse |-> fault_code == 4'h0);                         // R8
   AST_FSR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      fsr_q[FSR_W-1:8] == '0);                                      // R9
   AST_FAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_pulse |-> $stable(far_q));                             // R10
   AST_FSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_pulse |-> $stable(fsr_q));                             // R10

endmodule

bind domain_guard domain_guard_chk #(
   .DOM_W  (DOM_W),
   .ADDR_W (ADDR_W),
   .FSR_W  (FSR_W)
) i_domain_guard_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dacr_q      (dacr_q),
   .mmu_on      (mmu_on),
   .acc_valid   (acc_valid),
   .acc_domain  (acc_domain),
   .acc_grant   (acc_grant),
   .fault_pulse (fault_pulse),
   .fault_code  (fault_code),
   .fsr_q       (fsr_q),
   .far_q       (far_q)
);

// File: tb/test_domain_guard.sv
module test_domain_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dacr_wr = 1'b0;
   logic [31:0] dacr_wdata = '0;
   logic [31:0] dacr_q;
   logic        mmu_on = 1'b0;
   logic        acc_valid = 1'b0;
   logic [3:0]  acc_domain = '0;
   logic [31:0] acc_addr = '0;
   logic        perm_ok = 1'b0;
   logic        acc_grant;
   logic        fault_pulse;
   logic [3:0]  fault_code;
   logic [31:0] fsr_q;
   logic [31:0] far_q;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_fsr = '0;
   logic [31:0] exp_far = '0;

   always #4 clk = ~clk;   // 125 MHz

   domain_guard i_domain_guard (
      .clk(clk), .rst_n(rst_n), .dacr_wr(dacr_wr), .dacr_wdata(dacr_wdata),
      .dacr_q(dacr_q), .mmu_on(mmu_on), .acc_valid(acc_valid),
      .acc_domain(acc_domain), .acc_addr(acc_addr), .perm_ok(perm_ok),
      .acc_grant(acc_grant), .fault_pulse(fault_pulse), .fault_code(fault_code),
      .fsr_q(fsr_q), .far_q(far_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_ctrl(input logic [31:0] v);
      @(negedge clk);
      dacr_wr = 1'b1; dacr_wdata = v;
      @(negedge clk);
      dacr_wr = 1'b0;
      chk("R1 readback", dacr_q, v);
   endtask

   // One single-cycle access; pol is the code the requirements give its domain.
   task automatic access(input logic [3:0] dom, input logic [31:0] addr,
                         input logic perm, input logic mmu, input logic [1:0] pol);
      logic [3:0] code;
      logic       flt;
      logic       gnt;
      string      tag;
      code = 4'h0; flt = 1'b0; gnt = 1'b1;
      if (!mmu)                       tag = "R7";
      else if (pol == 2'b00)          begin tag = "R3"; flt = 1'b1; gnt = 1'b0; code = 4'h9; end
      else if (pol == 2'b10)          begin tag = "R4"; flt = 1'b1; gnt = 1'b0; code = 4'h9; end
      else if (pol == 2'b11)          tag = "R6";
      else begin
         tag = "R5";
         if (!perm) begin flt = 1'b1; gnt = 1'b0; code = 4'hD; end
      end
      @(negedge clk);
      acc_valid = 1'b1; acc_domain = dom; acc_addr = addr; perm_ok = perm; mmu_on = mmu;
      #1;
      chk({tag, " grant"}, {31'b0, acc_grant}, {31'b0, gnt});
      @(negedge clk);
      acc_valid = 1'b0;
      chk({tag, " R8 pulse"}, {31'b0, fault_pulse}, {31'b0, flt});
      chk({tag, " R8 code"}, {28'b0, fault_code}, {28'b0, code});
      if (flt) begin
         exp_fsr = {20'b0, 4'b0, dom, code};   // R9 layout
         exp_far = addr;
      end
      chk("R9 status word", fsr_q, exp_fsr);
      chk("R10 fault address", far_q, exp_far);
   endtask

   initial begin
      #200_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ctrl reset", dacr_q, 32'h0);
      chk("R1 fsr reset", fsr_q, 32'h0);
      chk("R1 far reset", far_q, 32'h0);
      chk("R1 pulse reset", {31'b0, fault_pulse}, 32'h0);
      // R11 idle: no grant with valid low
      #1 chk("R11 idle grant", {31'b0, acc_grant}, 32'h0);

      // R2 sweep: target domain gets code c, all others get 3-c.
      for (int c = 0; c < 4; c++) begin
         for (int d = 0; d < 16; d++) begin
            logic [31:0] v;
            for (int k = 0; k < 16; k++)
               v[2*k +: 2] = (k == d) ? 2'(c) : 2'(3 - c);
            write_ctrl(v);
            for (int m = 0; m < 4; m++) begin
               access(4'(d), 32'h1000_0000 + 32'(d * 64 + c * 8 + m),
                      m[0], m[1], 2'(c));
            end
         end
      end

      // R8: a held faulting access gives one pulse only.
      write_ctrl(32'h0000_0000);
      @(negedge clk);
      acc_valid = 1'b1; acc_domain = 4'd5; acc_addr = 32'hCAFE_0010; mmu_on = 1'b1;
      @(negedge clk);
      chk("R8 held first pulse", {31'b0, fault_pulse}, 32'h1);
      @(negedge clk);
      chk("R8 held no second pulse", {31'b0, fault_pulse}, 32'h0);
      acc_addr = 32'hDEAD_0020;
      @(negedge clk);
      chk("R8 held still no pulse", {31'b0, fault_pulse}, 32'h0);
      chk("R10 held keeps first address", far_q, 32'hCAFE_0010);
      chk("R9 held status", fsr_q, 32'h0000_0059);
      acc_valid = 1'b0;
      @(negedge clk);
      // R10: a granted access after the fault leaves the records alone.
      exp_fsr = 32'h0000_0059; exp_far = 32'hCAFE_0010;
      write_ctrl(32'hFFFF_FFFF);
      access(4'd9, 32'h1234_5678, 1'b0, 1'b1, 2'b11);
      // R11: inputs of a would-be fault with valid low produce nothing.
      write_ctrl(32'h0);
      @(negedge clk);
      acc_valid = 1'b0; acc_domain = 4'd2; mmu_on = 1'b1; acc_addr = 32'h5555_AAAA;
      #1 chk("R11 no grant when idle", {31'b0, acc_grant}, 32'h0);
      @(negedge clk);
      chk("R11 no pulse when idle", {31'b0, fault_pulse}, 32'h0);
      chk("R11 far unchanged when idle", far_q, 32'hCAFE_0010);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule